// File: doc/BRIEF.md
# JTAG TAP Master Scan Engine

This block is a JTAG host. It drives TCK, TMS and TDI toward one target TAP and samples TDO. Each command starts with a single-cycle strobe. A command can move the TAP to a stable state, shift an instruction or data scan of N bits, run N idle cycles, issue N clocks that keep the TAP where it is, or send N raw TMS bits. The engine keeps its own copy of the target's 16-state controller. From that copy it works out the TMS bits it needs, and it always takes the shortest walk to the target state.

Scan data goes out from a command word and comes back into a result word, least significant bit first. On the last scan bit TMS is raised, so the TAP leaves the shift state as that bit is shifted. A fixed prescaler parameter sets the TCK rate. A done strobe marks the end of each command, and TCK is then low.

Top module: `jtag_scan_engine`

## Requirements
- R1: After reset `tck` is 0, `busy` is 0, `done` is 0 and `tap_state` is Test-Logic-Reset (code 0). `tck` is 0 in every cycle where `busy` is 0.
- R2: Each TCK bit is DIV clock cycles low followed by DIV cycles high. TMS and TDI change only while TCK is low. TDO is sampled in the last low cycle, before the rise.
- R3: `tap_state` follows the standard TAP transitions on every TCK rise. The codes are: 0 Test-Logic-Reset, 1 Run-Test/Idle, 2 Select-DR, 3 Capture-DR, 4 Shift-DR, 5 Exit1-DR, 6 Pause-DR, 7 Exit2-DR, 8 Update-DR, 9 Select-IR, 10 Capture-IR, 11 Shift-IR, 12 Exit1-IR, 13 Pause-IR, 14 Exit2-IR, 15 Update-IR.
- R4: A move command (`cmd_op`=0) sends the shortest TMS walk to `cmd_end`, which is one of the stable codes 0, 1, 4, 6, 11 or 13. It sends no bits if the TAP is already in that state.
- R5: An instruction scan (`cmd_op`=1) or data scan (`cmd_op`=2) of `cmd_len` bits (1..MAX_BITS) does three things in order. First, if the TAP is not already in Shift-IR or Shift-DR respectively, it walks the shortest way there. Second, it shifts the bits with TMS=0 on every bit except the last, which has TMS=1. Third, it walks the shortest way from Exit1 to `cmd_end`.
- R6: Scan bit i is driven from `cmd_data[i]` at the i-th shift rise, and the TDO value sampled for that bit lands in `rx_data[i]`.
- R7: `cmd_mode[0]`=0 drives TDI low for the whole scan. `cmd_mode[1]`=0 leaves `rx_data` unchanged. `cmd_mode[1]`=1 clears the result bits above `cmd_len`.
- R8: A run-idle command (`cmd_op`=3) first walks to Run-Test/Idle. It then gives exactly `cmd_len` rises in Run-Test/Idle with TMS=0 and walks to `cmd_end`.
- R9: A stable-clock command (`cmd_op`=4) gives `cmd_len` rises with TMS=1 in Test-Logic-Reset and TMS=0 in any other state. The TAP state does not change, and `cmd_end` has no effect.
- R10: A raw TMS command (`cmd_op`=5) gives `cmd_len` rises with TMS equal to `cmd_data[i]` on rise i. `cmd_end` has no effect.
- R11: `done` pulses for one cycle, in the first cycle after the last TCK fall, with `busy` low. `cmd_start` is taken only while `busy` is low.
- R12: `trst` high forces `tap_state` to Test-Logic-Reset at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trst | input | 1 | Forces the internal TAP copy to Test-Logic-Reset |
| cmd_start | input | 1 | Starts the command on the cmd_* inputs |
| cmd_op | input | 3 | Command code, 0..5 |
| cmd_end | input | 4 | Requested end state code |
| cmd_len | input | CNT_W | Bit or cycle count |
| cmd_mode | input | 2 | Bit 0 drives data, bit 1 captures data |
| cmd_data | input | MAX_BITS | Scan data or raw TMS bits |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle end-of-command strobe |
| rx_data | output | MAX_BITS | Captured scan data |
| tap_state | output | 4 | Internal TAP state copy |
| tck | output | 1 | Test clock |
| tms | output | 1 | Test mode select |
| tdi | output | 1 | Test data to the target |
| tdo | input | 1 | Test data from the target |

## Verification
The TAP state copy updates at the same clock edge that raises TCK. So the bench's own target model, which moves on each TCK rise, has to agree with `tap_state` at every falling clock edge, and the bench compares the two on every cycle. The captured TDO for bit i is taken one edge before rise i, while the target model changes TDO just after each rise, so each result bit is already settled when it is sampled. `done` comes one cycle after TCK returns low. The bench waits for `done` and checks the rise counts, the logged TMS and TDI bits and `rx_data` in that same cycle. It compares the rise counts with shortest-walk distances that it works out for itself.

// File: rtl/jse_pkg.sv
package jse_pkg;

    typedef enum logic [3:0] {
        TAP_TLR   = 4'd0,  TAP_RTI   = 4'd1,  TAP_SELDR = 4'd2,  TAP_CAPDR = 4'd3,
        TAP_SDR   = 4'd4,  TAP_E1DR  = 4'd5,  TAP_PDR   = 4'd6,  TAP_E2DR  = 4'd7,
        TAP_UPDR  = 4'd8,  TAP_SELIR = 4'd9,  TAP_CAPIR = 4'd10, TAP_SIR   = 4'd11,
        TAP_E1IR  = 4'd12, TAP_PIR   = 4'd13, TAP_E2IR  = 4'd14, TAP_UPIR  = 4'd15
    } tap_e;

    typedef enum logic [2:0] {
        OP_MOVE   = 3'd0, OP_IRSCAN = 3'd1, OP_DRSCAN = 3'd2,
        OP_IDLE   = 3'd3, OP_STABLE = 3'd4, OP_TMS    = 3'd5
    } op_e;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0, PH_PRE = 3'd1, PH_BODY = 3'd2, PH_POST = 3'd3, PH_FIN = 3'd4
    } phase_e;

    typedef enum logic [1:0] {
        CK_IDLE = 2'd0, CK_LOW = 2'd1, CK_HIGH = 2'd2
    } ckph_e;

    function automatic tap_e tap_next(input tap_e s, input logic t);
        case (s)
            TAP_TLR:   return t ? TAP_TLR   : TAP_RTI;
            TAP_RTI:   return t ? TAP_SELDR : TAP_RTI;
            TAP_SELDR: return t ? TAP_SELIR : TAP_CAPDR;
            TAP_CAPDR: return t ? TAP_E1DR  : TAP_SDR;
            TAP_SDR:   return t ? TAP_E1DR  : TAP_SDR;
            TAP_E1DR:  return t ? TAP_UPDR  : TAP_PDR;
            TAP_PDR:   return t ? TAP_E2DR  : TAP_PDR;
            TAP_E2DR:  return t ? TAP_UPDR  : TAP_SDR;
            TAP_UPDR:  return t ? TAP_SELDR : TAP_RTI;
            TAP_SELIR: return t ? TAP_TLR   : TAP_CAPIR;
            TAP_CAPIR: return t ? TAP_E1IR  : TAP_SIR;
            TAP_SIR:   return t ? TAP_E1IR  : TAP_SIR;
            TAP_E1IR:  return t ? TAP_UPIR  : TAP_PIR;
            TAP_PIR:   return t ? TAP_E2IR  : TAP_PIR;
            TAP_E2IR:  return t ? TAP_UPIR  : TAP_SIR;
            default:   return t ? TAP_SELDR : TAP_RTI;
        endcase
    endfunction

endpackage

// File: rtl/jse_path.sv
// One step of the shortest walk: the TMS value that moves cur closer to tgt.
module jse_path
    import jse_pkg::*;
(
    input  tap_e cur,
    input  tap_e tgt,
    output logic step_tms
);
    logic to_dr_side;
    logic to_ir_side;

    always_comb begin
        to_dr_side = (tgt == TAP_SDR) || (tgt == TAP_PDR);
        to_ir_side = (tgt == TAP_SIR) || (tgt == TAP_PIR);
        case (cur)
            TAP_TLR:   step_tms = 1'b0;
            TAP_RTI:   step_tms = 1'b1;
            TAP_SELDR: step_tms = !to_dr_side;
            TAP_CAPDR: step_tms = (tgt != TAP_SDR);
            TAP_SDR:   step_tms = 1'b1;
            TAP_E1DR:  step_tms = !to_dr_side;
            TAP_PDR:   step_tms = 1'b1;
            TAP_E2DR:  step_tms = !to_dr_side;
            TAP_UPDR:  step_tms = (tgt != TAP_RTI);
            TAP_SELIR: step_tms = !to_ir_side;
            TAP_CAPIR: step_tms = (tgt != TAP_SIR);
            TAP_SIR:   step_tms = 1'b1;
            TAP_E1IR:  step_tms = !to_ir_side;
            TAP_PIR:   step_tms = 1'b1;
            TAP_E2IR:  step_tms = !to_ir_side;
            default:   step_tms = (tgt != TAP_RTI);
        endcase
    end
endmodule

// File: rtl/jse_tckgen.sv
// Bit timer: DIV cycles TCK low (TMS/TDI held, TDO sampled at end), DIV cycles high.
module jse_tckgen
    import jse_pkg::*;
#(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic go_tms,
    input  logic go_tdi,
    output logic tck,
    output logic tms,
    output logic tdi,
    output logic active,
    output logic sample,
    output logic last
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] CNT_END = CW'(DIV - 1);

    typedef struct packed {
        ckph_e          ph;
        logic [CW-1:0]  cnt;
        logic           tck;
        logic           tms;
        logic           tdi;
    } ck_t;

    ck_t ck_q, ck_d;

    always_comb begin
        ck_d   = ck_q;
        sample = (ck_q.ph == CK_LOW)  && (ck_q.cnt == CNT_END);
        last   = (ck_q.ph == CK_HIGH) && (ck_q.cnt == CNT_END);
        case (ck_q.ph)
            CK_IDLE: begin
                if (go) begin
                    ck_d.ph  = CK_LOW;
                    ck_d.cnt = '0;
                    ck_d.tms = go_tms;
                    ck_d.tdi = go_tdi;
                end
            end
            CK_LOW: begin
                if (ck_q.cnt == CNT_END) begin
                    ck_d.ph  = CK_HIGH;
                    ck_d.cnt = '0;
                    ck_d.tck = 1'b1;
                end else begin
                    ck_d.cnt = ck_q.cnt + 1'b1;
                end
            end
            default: begin
                if (ck_q.cnt == CNT_END) begin
                    ck_d.tck = 1'b0;
                    ck_d.cnt = '0;
                    if (go) begin
                        ck_d.ph  = CK_LOW;
                        ck_d.tms = go_tms;
                        ck_d.tdi = go_tdi;
                    end else begin
                        ck_d.ph  = CK_IDLE;
                    end
                end else begin
                    ck_d.cnt = ck_q.cnt + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ck_q <= '{ph: CK_IDLE, cnt: '0, tck: 1'b0, tms: 1'b0, tdi: 1'b0};
        end else begin
            ck_q <= ck_d;
        end
    end

    assign tck    = ck_q.tck;
    assign tms    = ck_q.tms;
    assign tdi    = ck_q.tdi;
    assign active = (ck_q.ph != CK_IDLE);

    // R2: the sample cycle is directly followed by the rising edge
    a_r2_rise_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
        sample |=> tck);
    // R2: a bit with nothing queued behind it ends with TCK low
    a_r2_low_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        (last && !go) |=> (!tck && !active));
endmodule

// File: rtl/jse_seq.sv
// Command sequencer: pre-walk, body bits, post-walk; keeps the TAP state copy.
module jse_seq
    import jse_pkg::*;
#(
    parameter int MAX_BITS = 32,
    parameter int CNT_W    = $clog2(MAX_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                trst,
    input  logic                cmd_start,
    input  logic [2:0]          cmd_op,
    input  logic [3:0]          cmd_end,
    input  logic [CNT_W-1:0]    cmd_len,
    input  logic [1:0]          cmd_mode,
    input  logic [MAX_BITS-1:0] cmd_data,
    input  logic                tdo,
    input  logic                slot,
    input  logic                active,
    input  logic                sample,
    input  logic                cur_tms,
    output logic                go,
    output logic                go_tms,
    output logic                go_tdi,
    output logic                busy,
    output logic                done,
    output logic [MAX_BITS-1:0] rx_data,
    output logic [3:0]          tap_state
);
    localparam int IW = (MAX_BITS > 1) ? $clog2(MAX_BITS) : 1;

    typedef struct packed {
        phase_e              phase;
        op_e                 op;
        tap_e                end_st;
        tap_e                pre_tgt;
        tap_e                state;
        logic [CNT_W-1:0]    count;
        logic [CNT_W-1:0]    idx;
        logic [IW-1:0]       cur_idx;
        logic                cap;
        logic [1:0]          mode;
        logic [MAX_BITS-1:0] data;
        logic [MAX_BITS-1:0] rx;
        logic                done;
    } seq_t;

    seq_t   q, d;
    phase_e ph;
    tap_e   walk_tgt;
    logic   walk_tms;
    logic   has_post;
    logic   last_body;
    logic   b_tms, b_tdi, b_cap;
    logic [IW-1:0] sidx;
    op_e    new_op;

    // Effective phase at the next bit slot
    always_comb begin
        has_post = (q.op == OP_MOVE) || (q.op == OP_IRSCAN) ||
                   (q.op == OP_DRSCAN) || (q.op == OP_IDLE);
        ph = q.phase;
        if (ph == PH_PRE && q.state == q.pre_tgt) ph = PH_BODY;
        if (ph == PH_BODY && q.idx == q.count)    ph = PH_POST;
        if (ph == PH_POST && (!has_post || q.state == q.end_st)) ph = PH_FIN;
        walk_tgt = (ph == PH_PRE) ? q.pre_tgt : q.end_st;
    end

    jse_path u_path (
        .cur      (q.state),
        .tgt      (walk_tgt),
        .step_tms (walk_tms)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        go     = 1'b0;
        go_tms = 1'b0;
        go_tdi = 1'b0;
        sidx      = q.idx[IW-1:0];
        last_body = (q.idx == q.count - 1'b1);
        new_op    = op_e'(cmd_op);

        case (q.op)
            OP_IRSCAN, OP_DRSCAN: begin
                b_tms = last_body;
                b_tdi = q.mode[0] & q.data[sidx];
                b_cap = q.mode[1];
            end
            OP_STABLE: begin
                b_tms = (q.state == TAP_TLR);
                b_tdi = 1'b0;
                b_cap = 1'b0;
            end
            OP_TMS: begin
                b_tms = q.data[sidx];
                b_tdi = 1'b0;
                b_cap = 1'b0;
            end
            default: begin
                b_tms = 1'b0;
                b_tdi = 1'b0;
                b_cap = 1'b0;
            end
        endcase

        if (sample) begin
            d.state = tap_next(q.state, cur_tms);
            if (q.cap) d.rx[q.cur_idx] = tdo;
        end

        if (q.phase != PH_IDLE && slot) begin
            if (ph == PH_FIN) begin
                if (!active) begin
                    d.phase = PH_IDLE;
                    d.done  = 1'b1;
                end
            end else begin
                go      = 1'b1;
                d.phase = ph;
                if (ph == PH_BODY) begin
                    go_tms    = b_tms;
                    go_tdi    = b_tdi;
                    d.cap     = b_cap;
                    d.cur_idx = sidx;
                    d.idx     = q.idx + 1'b1;
                end else begin
                    go_tms = walk_tms;
                    d.cap  = 1'b0;
                end
            end
        end

        if (q.phase == PH_IDLE && cmd_start) begin
            d.phase  = PH_PRE;
            d.op     = new_op;
            d.end_st = tap_e'(cmd_end);
            d.mode   = cmd_mode;
            d.data   = cmd_data;
            d.idx    = '0;
            d.cap    = 1'b0;
            d.count  = (new_op == OP_MOVE) ? '0 : cmd_len;
            case (new_op)
                OP_IRSCAN: d.pre_tgt = TAP_SIR;
                OP_DRSCAN: d.pre_tgt = TAP_SDR;
                OP_IDLE:   d.pre_tgt = TAP_RTI;
                default:   d.pre_tgt = q.state;
            endcase
            if ((new_op == OP_IRSCAN || new_op == OP_DRSCAN) && cmd_mode[1]) d.rx = '0;
        end

        if (trst) d.state = TAP_TLR;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{phase: PH_IDLE, op: OP_MOVE, end_st: TAP_TLR, pre_tgt: TAP_TLR,
                   state: TAP_TLR, count: '0, idx: '0, cur_idx: '0, cap: 1'b0,
                   mode: 2'b00, data: '0, rx: '0, done: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign busy      = (q.phase != PH_IDLE);
    assign done      = q.done;
    assign rx_data   = q.rx;
    assign tap_state = q.state;

    // R12: reset pin lands the TAP copy in Test-Logic-Reset
    a_r12_trst_to_tlr: assert property (@(posedge clk) disable iff (!rst_n)
        trst |=> (q.state == TAP_TLR));
    // R9: a stable-clock rise never moves the TAP copy
    a_r9_stable_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && q.op == OP_STABLE && sample && !trst) |=> $stable(q.state));
    // R11: done is a single-cycle strobe
    a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/jtag_scan_engine.sv
module jtag_scan_engine
    import jse_pkg::*;
#(
    parameter int MAX_BITS = 32,
    parameter int DIV      = 2,
    parameter int CNT_W    = $clog2(MAX_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                trst,
    input  logic                cmd_start,
    input  logic [2:0]          cmd_op,
    input  logic [3:0]          cmd_end,
    input  logic [CNT_W-1:0]    cmd_len,
    input  logic [1:0]          cmd_mode,
    input  logic [MAX_BITS-1:0] cmd_data,
    output logic                busy,
    output logic                done,
    output logic [MAX_BITS-1:0] rx_data,
    output logic [3:0]          tap_state,
    output logic                tck,
    output logic                tms,
    output logic                tdi,
    input  logic                tdo
);
    logic go, go_tms, go_tdi;
    logic active, sample, last;
    logic slot;

    assign slot = !active || last;

    jse_tckgen #(.DIV(DIV)) u_tckgen (
        .clk    (clk),
        .rst_n  (rst_n),
        .go     (go),
        .go_tms (go_tms),
        .go_tdi (go_tdi),
        .tck    (tck),
        .tms    (tms),
        .tdi    (tdi),
        .active (active),
        .sample (sample),
        .last   (last)
    );

    jse_seq #(.MAX_BITS(MAX_BITS), .CNT_W(CNT_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .trst      (trst),
        .cmd_start (cmd_start),
        .cmd_op    (cmd_op),
        .cmd_end   (cmd_end),
        .cmd_len   (cmd_len),
        .cmd_mode  (cmd_mode),
        .cmd_data  (cmd_data),
        .tdo       (tdo),
        .slot      (slot),
        .active    (active),
        .sample    (sample),
        .cur_tms   (tms),
        .go        (go),
        .go_tms    (go_tms),
        .go_tdi    (go_tdi),
        .busy      (busy),
        .done      (done),
        .rx_data   (rx_data),
        .tap_state (tap_state)
    );

    // R1: the clock rests low whenever no command runs
    a_r1_idle_tck_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !tck);
    // R11: the done cycle has TCK low and the engine idle
    a_r11_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!tck && !busy));
endmodule

// File: tb/jtag_scan_engine_tb.sv
module jtag_scan_engine_tb;
    localparam int DIV = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trst = 1'b0;
    logic        cmd_start = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic [3:0]  cmd_end = '0;
    logic [5:0]  cmd_len = '0;
    logic [1:0]  cmd_mode = '0;
    logic [31:0] cmd_data = '0;
    logic        busy, done, tck, tms, tdi;
    logic [31:0] rx_data;
    logic [3:0]  tap_state;
    logic        tdo_r = 1'b0;

    always #10 clk = ~clk;

    jtag_scan_engine #(.MAX_BITS(32), .DIV(DIV)) u_dut (
        .clk(clk), .rst_n(rst_n), .trst(trst), .cmd_start(cmd_start),
        .cmd_op(cmd_op), .cmd_end(cmd_end), .cmd_len(cmd_len), .cmd_mode(cmd_mode),
        .cmd_data(cmd_data), .busy(busy), .done(done), .rx_data(rx_data),
        .tap_state(tap_state), .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo_r)
    );

    int n_checks = 0;
    int n_err = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Standard TAP transitions, codes as in the requirements
    function automatic int bnext(input int s, input int t);
        case (s)
            0:  return t ? 0 : 1;
            1:  return t ? 2 : 1;
            2:  return t ? 9 : 3;
            3:  return t ? 5 : 4;
            4:  return t ? 5 : 4;
            5:  return t ? 8 : 6;
            6:  return t ? 7 : 6;
            7:  return t ? 8 : 4;
            8:  return t ? 2 : 1;
            9:  return t ? 0 : 10;
            10: return t ? 12 : 11;
            11: return t ? 12 : 11;
            12: return t ? 15 : 13;
            13: return t ? 14 : 13;
            14: return t ? 15 : 11;
            default: return t ? 2 : 1;
        endcase
    endfunction

    // Shortest number of TMS bits from a to b, by repeated relaxation
    function automatic int bdist(input int a, input int b);
        int dd[16];
        for (int s = 0; s < 16; s++) dd[s] = 99;
        dd[b] = 0;
        for (int it = 0; it < 16; it++) begin
            for (int s = 0; s < 16; s++) begin
                if (s != b) begin
                    int m0 = dd[bnext(s, 0)];
                    int m1 = dd[bnext(s, 1)];
                    int m  = ((m0 < m1) ? m0 : m1) + 1;
                    if (m < dd[s]) dd[s] = m;
                end
            end
        end
        return dd[a];
    endfunction

    // Behavioural target TAP: moves on every TCK rise, logs shift bits, drives TDO
    int tstate = 0;
    int n_edge = 0;
    int n_idle = 0;
    int shk = 0;
    logic [31:0] tdi_log = '0;
    logic [31:0] tms_log = '0;
    logic [31:0] tpat = '0;

    always @(posedge tck or posedge trst) begin
        if (trst) begin
            tstate = 0;
        end else begin
            n_edge++;
            if (tstate == 1 && tms == 1'b0) n_idle++;
            if (tstate == 4 || tstate == 11) begin
                if (shk < 32) begin
                    tdi_log[shk] = tdi;
                    tms_log[shk] = tms;
                end
                shk++;
                if (shk < 32) tdo_r = tpat[shk];
            end
            tstate = bnext(tstate, int'(tms));
        end
    end

    // Per-cycle comparison against the reference
    logic prev_tck = 1'b0, prev_tms = 1'b0, prev_tdi = 1'b0;
    int   hi_len = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!busy) chk(tck == 1'b0, "R1", "tck while idle", tck, 0);
            if (!trst) chk(int'(tap_state) == tstate, "R3", "tap_state vs target", tap_state, tstate);
            if (tck && prev_tck)
                chk(tms == prev_tms && tdi == prev_tdi, "R2", "TMS/TDI moved while TCK high",
                    {tms, tdi}, {prev_tms, prev_tdi});
            if (tck) hi_len++;
            else if (hi_len != 0) begin
                chk(hi_len == DIV, "R2", "TCK high length", hi_len, DIV);
                hi_len = 0;
            end
        end
        prev_tck = tck;
        prev_tms = tms;
        prev_tdi = tdi;
    end

    task automatic run(input int op, input int endst, input int n, input int mode,
                       input logic [31:0] data, input logic [31:0] pat, output int s0);
        int cyc;
        @(negedge clk);
        s0 = tstate;
        n_edge = 0; n_idle = 0; shk = 0;
        tdi_log = '0; tms_log = '0;
        tpat = pat; tdo_r = pat[0];
        cmd_op = 3'(op); cmd_end = 4'(endst); cmd_len = 6'(n);
        cmd_mode = 2'(mode); cmd_data = data;
        cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        cyc = 0;
        while (!done && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
        chk(done == 1'b1, "R11", "done seen", done, 1);
        chk(tck == 1'b0 && busy == 1'b0, "R11", "tck/busy at done", {tck, busy}, 0);
        @(negedge clk);
        chk(done == 1'b0, "R11", "done one cycle", done, 0);
    endtask

    task automatic do_move(input int endst);
        int s0;
        run(0, endst, 0, 0, '0, '0, s0);
        chk(n_edge == bdist(s0, endst), "R4", "move bit count", n_edge, bdist(s0, endst));
        chk(tstate == endst, "R4", "move end state", tstate, endst);
    endtask

    task automatic do_scan(input bit ir, input int endst, input int n, input int mode,
                           input logic [31:0] data, input logic [31:0] pat);
        int s0, sh, ex;
        logic [31:0] mask, rx_before, exp_rx;
        rx_before = rx_data;
        run(ir ? 1 : 2, endst, n, mode, data, pat, s0);
        sh = ir ? 11 : 4;
        ex = ((s0 == sh) ? 0 : bdist(s0, sh)) + n + bdist(sh + 1, endst);
        mask = (n == 32) ? 32'hffff_ffff : ((32'd1 << n) - 1);
        chk(n_edge == ex, "R5", "scan bit count", n_edge, ex);
        chk(tstate == endst, "R5", "scan end state", tstate, endst);
        chk(shk == n, "R5", "rises in shift", shk, n);
        chk((tms_log & mask) == (32'd1 << (n - 1)), "R5", "TMS in shift", tms_log & mask,
            32'd1 << (n - 1));
        if (mode[0]) chk((tdi_log & mask) == (data & mask), "R6", "TDI bits", tdi_log & mask, data & mask);
        else         chk((tdi_log & mask) == 0, "R7", "TDI low on read-only", tdi_log & mask, 0);
        exp_rx = mode[1] ? (pat & mask) : rx_before;
        if (mode[1]) chk(rx_data == exp_rx, "R6", "captured TDO", rx_data, exp_rx);
        else         chk(rx_data == exp_rx, "R7", "rx kept on write-only", rx_data, exp_rx);
    endtask

    // Watchdog
    initial begin
        #3_000_000;
        chk(1'b0, "R11", "watchdog expired", 0, 1);
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

    initial begin
        int s0;
        logic [31:0] rx_hold;
        repeat (3) @(negedge clk);
        chk(tck == 1'b0 && busy == 1'b0 && done == 1'b0, "R1", "outputs in reset",
            {tck, busy, done}, 0);
        chk(tap_state == 4'd0, "R1", "state in reset", tap_state, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        do_move(1);                                  // R4 TLR -> RTI
        do_move(13);                                 // R4 RTI -> Pause-IR
        do_move(13);                                 // R4 already there: zero bits
        do_scan(1'b0, 1, 8, 3, 32'h0000_00a5, 32'h0000_003c);   // R5 R6 from Pause-IR
        do_scan(1'b1, 6, 5, 3, 32'h0000_0013, 32'h0000_0019);   // R5 IR, end Pause-DR
        do_scan(1'b0, 4, 32, 2, 32'hffff_ffff, 32'hdead_beef);  // R7 read-only, end Shift-DR
        rx_hold = rx_data;
        do_scan(1'b0, 1, 12, 1, 32'h0000_0b6d, 32'h0000_0fff);  // R7 write-only, starts in Shift-DR
        chk(rx_data == rx_hold, "R7", "rx after write-only", rx_data, rx_hold);
        do_scan(1'b0, 1, 1, 3, 32'h1, 32'h1);                   // R5 single bit

        run(3, 13, 5, 0, '0, '0, s0);                // R8 from RTI, end Pause-IR
        chk(n_idle == 5, "R8", "idle rises", n_idle, 5);
        chk(tstate == 13, "R8", "idle end state", tstate, 13);
        run(3, 1, 3, 0, '0, '0, s0);                 // R8 from Pause-IR, end RTI
        chk(n_idle == 3, "R8", "idle rises from pause", n_idle, 3);
        chk(n_edge == bdist(13, 1) + 3, "R8", "idle total rises", n_edge, bdist(13, 1) + 3);

        do_move(0);
        run(4, 6, 4, 0, '0, '0, s0);                 // R9 in TLR, end_state ignored
        chk(n_edge == 4 && tstate == 0, "R9", "stable in TLR", {n_edge, tstate}, {4, 0});
        do_move(6);
        run(4, 0, 3, 0, '0, '0, s0);                 // R9 in Pause-DR
        chk(n_edge == 3 && tstate == 6, "R9", "stable in Pause-DR", {n_edge, tstate}, {3, 6});

        begin
            int exp_s;
            logic [31:0] bits = 32'b0011_0110;
            exp_s = tstate;
            for (int i = 0; i < 8; i++) exp_s = bnext(exp_s, int'(bits[i]));
            run(5, 0, 8, 0, bits, '0, s0);           // R10 raw TMS, end_state ignored
            chk(n_edge == 8, "R10", "raw TMS rises", n_edge, 8);
            chk(tstate == exp_s, "R10", "raw TMS end state", tstate, exp_s);
        end

        do_move(4);
        @(negedge clk);
        trst = 1'b1;                                 // R12
        @(negedge clk);
        chk(tap_state == 4'd0, "R12", "trst forces TLR", tap_state, 0);
        trst = 1'b0;
        @(negedge clk);
        chk(tap_state == 4'd0 && tck == 1'b0, "R12", "stays TLR after trst", {tap_state, tck}, 0);
        do_move(1);

        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end
endmodule